// File: doc/BRIEF.md
# Flash Page Protection Guard

This block stands between an on-chip flash array and everything that asks to program it or to read it out through the debug or serial-programming path. For every access it returns a single allow bit. Pages are guarded in groups of four, and each group has one bit in a 32-bit protection word. A cleared bit protects its group.

Two words combine to give the result. The first is a volatile word that software can set and clear at will. It takes effect at once and returns to all ones at every reset. The second is a persistent word held in a small non-volatile store model. It is guarded by a 32-bit key and is copied into an active register only when the block is reset. Software changes the persistent word by staging a new value, enabling the key in the mode register, loading the key halves, issuing the save command and polling status. The change then waits for the next reset.

Two key values are special. A saved key equal to the lock value makes the persistent word unchangeable. A mass-erase command returns the store to its blank state, which clears both the protection and the key.

Top module: `flash_guard`

## Requirements
- R1: After reset the register reads return these values: mode register (address 0) 0x80, key-low (1) 0, key-high (2) 0, staged persistent word (3) 0x00000000, volatile word (4) 0xFFFFFFFF, and status (5) 0. The status register holds busy in bit 0, pass in bit 1 and fail in bit 2.
- R2: Write an access with acc_write high to page p. It is denied when bit p/4 of the effective word is 0. A direct write of the volatile word changes this on the next cycle and needs no key.
- R3: With acc_dbg_read high and acc_write low, the access is allowed only when bit 31 of the effective word is 1. An access with both acc_write and acc_dbg_read low is always allowed, and bit 31 never affects a write.
- R4: The effective word is the bitwise AND of the active persistent word (readable at address 6) and the volatile word. A group is protected when either word has its bit cleared.
- R5: Writing the staged word, or completing a save, leaves the active word and every access decision unchanged until the next reset.
- R6: A save command is command code 0x0C. It requires mode bit 6 set and mode bit 5 clear. The key is {key-high, key-low}. When the save passes, the store takes the staged word and the key, and the next reset loads the staged word into the active word.
- R7: A save fails and leaves the store unchanged when mode bit 5 is set or mode bit 6 is clear.
- R8: Once a key is stored, a save with a different key fails and the store is unchanged. A save with the stored key passes.
- R9: A stored key of 0xDEADDEAD refuses every later save, even one made with that same key. The persistent word then stays unchanged.
- R10: Command code 0x0D is mass erase and always passes. After the next reset the active word is 0xFFFFFFFF, and any key is accepted by the next save.
- R11: The store keeps its contents through rst_n. Every reset reloads the active word from the store and sets the volatile word back to all ones.
- R12: After a command is taken, busy stays high for exactly SAVE_CYCLES cycles, and then exactly one of pass or fail is set. A command presented while busy is ignored.
- R13: Bits 0 to 30 each guard pages 4n to 4n+3. Pages in groups 31 and above are never write-protected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also reloads the active word from the store |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational from bus_addr) |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code (0x0C save, 0x0D mass erase) |
| stat_busy | output | 1 | Command in progress |
| stat_pass | output | 1 | Last command passed |
| stat_fail | output | 1 | Last command failed |
| acc_page | input | 7 | Page of the access being judged |
| acc_write | input | 1 | The access is a program or erase |
| acc_dbg_read | input | 1 | The access is a read through the debug or serial-programming path |
| acc_allow | output | 1 | The access may proceed |

## Verification
The assertions assume that rst_n is held low for at least one clock before any command is given. They also assume that cmd_valid is never raised during reset, and that acc_page together with the access type stays stable across the cycle in which acc_allow is sampled. The stimulus meets these conditions. It drives every input on the falling edge, leaves rst_n low for two clocks, and waits for busy to fall before it starts the next command, except in the one case that deliberately presents a command while busy. The lock assertion assumes that the only way out of a locked store is mass erase. The bench therefore always tries an ordinary save against a locked store before it erases.

// File: rtl/fg_pkg.sv
// Package fg_pkg: constants and types shared by the protection guard.
// Assumes a 32-bit protection word and a 32-bit key split into 16-bit halves.
package fg_pkg;
    localparam int WORD_W   = 32;
    localparam int HALF_W   = WORD_W / 2;
    localparam int MODE_W   = 8;
    localparam int CODE_W   = 8;
    localparam int KEN_BIT  = 6;   // key enable
    localparam int BAD_BIT  = 5;   // must be clear for a save
    localparam logic [MODE_W-1:0] MODE_RST  = 8'h80;
    localparam logic [CODE_W-1:0] OP_SAVE   = 8'h0C;
    localparam logic [CODE_W-1:0] OP_ERASE  = 8'h0D;
    localparam logic [WORD_W-1:0] KEY_LOCK  = 32'hDEAD_DEAD;
    localparam logic [WORD_W-1:0] KEY_BLANK = 32'hFFFF_FFFF;

    typedef enum logic [2:0] {
        RA_MODE  = 3'd0,
        RA_KEYLO = 3'd1,
        RA_KEYHI = 3'd2,
        RA_STAGE = 3'd3,
        RA_VOL   = 3'd4,
        RA_STAT  = 3'd5,
        RA_ACT   = 3'd6
    } reg_addr_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_SAVE  = 2'd1,
        SQ_ERASE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/fg_nvstore.sv
// Module fg_nvstore: behavioural non-volatile store for the persistent
// protection word and its key. It has no reset, so its contents survive rst_n.
// It starts blank (all ones). Erase takes priority over write.
module fg_nvstore
    import fg_pkg::*;
(
    input  logic              clk,
    input  logic              wr_en,
    input  logic              erase_en,
    input  logic [WORD_W-1:0] wr_prot,
    input  logic [WORD_W-1:0] wr_key,
    output logic [WORD_W-1:0] prot_q,
    output logic [WORD_W-1:0] key_q
);
    logic [WORD_W-1:0] prot_r = '1;
    logic [WORD_W-1:0] key_r  = KEY_BLANK;

    // Update the stored word and key on erase or on an accepted save.
    always_ff @(posedge clk) begin
        if (erase_en) begin
            prot_r <= '1;
            key_r  <= KEY_BLANK;
        end else if (wr_en) begin
            prot_r <= wr_prot;
            key_r  <= wr_key;
        end
    end

    assign prot_q = prot_r;
    assign key_q  = key_r;
endmodule

// File: rtl/fg_keyseq.sv
// Module fg_keyseq: runs the save and mass-erase commands. The verdict is
// decided when the command is taken. The store is written in the final busy
// cycle, and pass or fail is latched when busy ends.
// Assumes SAVE_CYCLES >= 1. Commands that arrive while busy are dropped.
module fg_keyseq
    import fg_pkg::*;
#(
    parameter int SAVE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic [MODE_W-1:0] mode_q,
    input  logic [WORD_W-1:0] stage_q,
    input  logic [WORD_W-1:0] key_in,
    input  logic [WORD_W-1:0] nv_key,
    output logic              busy,
    output logic              pass,
    output logic              fail,
    output logic              st_wr,
    output logic              st_erase,
    output logic [WORD_W-1:0] st_prot,
    output logic [WORD_W-1:0] st_key
);
    localparam int CNT_W = $clog2(SAVE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAVE_CYCLES - 1);

    seq_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              verdict_q;
    logic              pass_q;
    logic              fail_q;
    logic [WORD_W-1:0] prot_cap;
    logic [WORD_W-1:0] key_cap;
    logic              key_accept;
    logic              mode_ok;
    logic              save_ok;

    // Decide whether a save issued now would be accepted.
    always_comb begin
        key_accept = (nv_key != KEY_LOCK) &&
                     ((nv_key == KEY_BLANK) || (nv_key == key_in));
        mode_ok    = mode_q[KEN_BIT] && !mode_q[BAD_BIT];
        save_ok    = key_accept && mode_ok;
    end

    // Take commands, count the busy window and latch the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SQ_IDLE;
            cnt_q     <= '0;
            verdict_q <= 1'b0;
            pass_q    <= 1'b0;
            fail_q    <= 1'b0;
            prot_cap  <= '0;
            key_cap   <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (cmd_valid && cmd_code == OP_SAVE) begin
                        state_q   <= SQ_SAVE;
                        cnt_q     <= CNT_LAST;
                        verdict_q <= save_ok;
                        prot_cap  <= stage_q;
                        key_cap   <= key_in;
                        pass_q    <= 1'b0;
                        fail_q    <= 1'b0;
                    end else if (cmd_valid && cmd_code == OP_ERASE) begin
                        state_q   <= SQ_ERASE;
                        cnt_q     <= CNT_LAST;
                        verdict_q <= 1'b1;
                        pass_q    <= 1'b0;
                        fail_q    <= 1'b0;
                    end
                end
                default: begin
                    if (cnt_q == '0) begin
                        state_q <= SQ_IDLE;
                        pass_q  <= verdict_q;
                        fail_q  <= !verdict_q;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy     = (state_q != SQ_IDLE);
    assign pass     = pass_q;
    assign fail     = fail_q;
    assign st_wr    = (state_q == SQ_SAVE) && (cnt_q == '0) && verdict_q;
    assign st_erase = (state_q == SQ_ERASE) && (cnt_q == '0);
    assign st_prot  = prot_cap;
    assign st_key   = key_cap;
endmodule

// File: rtl/fg_access.sv
// Module fg_access: combinational allow/deny decision for a single access.
// Assumes active-low protection bits. Bit WORD_W-1 gates debug reads and the
// lower bits guard page groups of GROUP_PAGES pages each.
module fg_access
    import fg_pkg::*;
#(
    parameter int PAGE_W      = 7,
    parameter int GROUP_PAGES = 4
) (
    input  logic [WORD_W-1:0] act_word,
    input  logic [WORD_W-1:0] vol_word,
    input  logic [PAGE_W-1:0] acc_page,
    input  logic              acc_write,
    input  logic              acc_dbg_read,
    output logic              acc_allow
);
    localparam int SHIFT   = $clog2(GROUP_PAGES);
    localparam int GUARDED = WORD_W - 1;
    localparam int IDX_W   = $clog2(WORD_W);

    logic [WORD_W-1:0] eff;
    logic [PAGE_W-1:0] grp;
    logic              grp_open;

    // Merge both words, find the page group and pick the bit that applies.
    always_comb begin
        eff = act_word & vol_word;
        grp = acc_page >> SHIFT;
        if (grp < PAGE_W'(GUARDED)) grp_open = eff[grp[IDX_W-1:0]];
        else                        grp_open = 1'b1;
        if (acc_write)         acc_allow = grp_open;
        else if (acc_dbg_read) acc_allow = eff[WORD_W-1];
        else                   acc_allow = 1'b1;
    end
endmodule

// File: rtl/flash_guard.sv
// Module flash_guard: top of the flash protection guard. It holds the register
// file (mode, key halves, staged persistent word, volatile word) and the active
// persistent copy, which is reloaded from the store on every reset.
// Assumes synchronous active-low reset and a single-cycle register bus.
module flash_guard
    import fg_pkg::*;
#(
    parameter int PAGE_W      = 7,
    parameter int GROUP_PAGES = 4,
    parameter int SAVE_CYCLES = 4,
    parameter int ADDR_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              cmd_valid,
    input  logic [CODE_W-1:0] cmd_code,
    output logic              stat_busy,
    output logic              stat_pass,
    output logic              stat_fail,
    input  logic [PAGE_W-1:0] acc_page,
    input  logic              acc_write,
    input  logic              acc_dbg_read,
    output logic              acc_allow
);
    logic [MODE_W-1:0] mode_q;
    logic [HALF_W-1:0] keylo_q;
    logic [HALF_W-1:0] keyhi_q;
    logic [WORD_W-1:0] stage_q;
    logic [WORD_W-1:0] vol_q;
    logic [WORD_W-1:0] act_prot;
    logic [WORD_W-1:0] nv_prot;
    logic [WORD_W-1:0] nv_key;
    logic [WORD_W-1:0] key_in;
    logic              st_wr;
    logic              st_erase;
    logic [WORD_W-1:0] st_prot;
    logic [WORD_W-1:0] st_key;
    logic [2:0]        stat_word;

    assign key_in = {keyhi_q, keylo_q};

    // Software-visible registers: reset defaults and bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_RST;
            keylo_q <= '0;
            keyhi_q <= '0;
            stage_q <= '0;
            vol_q   <= '1;
        end else if (bus_wr) begin
            case (bus_addr)
                ADDR_W'(RA_MODE):  mode_q  <= bus_wdata[MODE_W-1:0];
                ADDR_W'(RA_KEYLO): keylo_q <= bus_wdata[HALF_W-1:0];
                ADDR_W'(RA_KEYHI): keyhi_q <= bus_wdata[HALF_W-1:0];
                ADDR_W'(RA_STAGE): stage_q <= bus_wdata;
                ADDR_W'(RA_VOL):   vol_q   <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Active persistent copy: loaded from the store only while in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) act_prot <= nv_prot;
    end

    // Register read mux.
    always_comb begin
        case (bus_addr)
            ADDR_W'(RA_MODE):  bus_rdata = {{(WORD_W-MODE_W){1'b0}}, mode_q};
            ADDR_W'(RA_KEYLO): bus_rdata = {{HALF_W{1'b0}}, keylo_q};
            ADDR_W'(RA_KEYHI): bus_rdata = {{HALF_W{1'b0}}, keyhi_q};
            ADDR_W'(RA_STAGE): bus_rdata = stage_q;
            ADDR_W'(RA_VOL):   bus_rdata = vol_q;
            ADDR_W'(RA_STAT):  bus_rdata = {{(WORD_W-3){1'b0}}, stat_word};
            ADDR_W'(RA_ACT):   bus_rdata = act_prot;
            default:           bus_rdata = '0;
        endcase
    end

    assign stat_word = {stat_fail, stat_pass, stat_busy};

    fg_nvstore u_store (
        .clk      (clk),
        .wr_en    (st_wr),
        .erase_en (st_erase),
        .wr_prot  (st_prot),
        .wr_key   (st_key),
        .prot_q   (nv_prot),
        .key_q    (nv_key)
    );

    fg_keyseq #(.SAVE_CYCLES(SAVE_CYCLES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .mode_q    (mode_q),
        .stage_q   (stage_q),
        .key_in    (key_in),
        .nv_key    (nv_key),
        .busy      (stat_busy),
        .pass      (stat_pass),
        .fail      (stat_fail),
        .st_wr     (st_wr),
        .st_erase  (st_erase),
        .st_prot   (st_prot),
        .st_key    (st_key)
    );

    fg_access #(.PAGE_W(PAGE_W), .GROUP_PAGES(GROUP_PAGES)) u_acc (
        .act_word     (act_prot),
        .vol_word     (vol_q),
        .acc_page     (acc_page),
        .acc_write    (acc_write),
        .acc_dbg_read (acc_dbg_read),
        .acc_allow    (acc_allow)
    );
endmodule

// File: rtl/fg_checker.sv
// Module fg_checker: temporal checks on the guard, bound to flash_guard.
// Assumes reset is asserted before the first command.
module fg_checker
    import fg_pkg::*;
#(
    parameter int PAGE_W      = 7,
    parameter int GROUP_PAGES = 4,
    parameter int SAVE_CYCLES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              pass,
    input logic              fail,
    input logic [WORD_W-1:0] act_word,
    input logic [WORD_W-1:0] vol_word,
    input logic [WORD_W-1:0] nv_prot,
    input logic [WORD_W-1:0] nv_key,
    input logic [PAGE_W-1:0] acc_page,
    input logic              acc_write,
    input logic              acc_dbg_read,
    input logic              acc_allow
);
    localparam int SHIFT = $clog2(GROUP_PAGES);
    localparam int RUN_W = $clog2(SAVE_CYCLES + 2) + 1;

    logic [RUN_W-1:0]  busy_run;
    logic [PAGE_W-1:0] grp;
    logic              vol_blocks;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else           busy_run <= '0;
    end

    // Work out whether the volatile word alone protects the requested page.
    always_comb begin
        grp        = acc_page >> SHIFT;
        vol_blocks = (grp < PAGE_W'(WORD_W - 1)) && !vol_word[grp[4:0]];
    end

    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= RUN_W'(SAVE_CYCLES)); // R12
    AST_PASS_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && fail)); // R12
    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(act_word)); // R5
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_key == KEY_LOCK) |=> ((nv_prot == $past(nv_prot)) || (nv_key == KEY_BLANK))); // R9
    AST_VOL_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_write && vol_blocks) |-> !acc_allow); // R2
    AST_DBG_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_dbg_read && !acc_write && !vol_word[WORD_W-1]) |-> !acc_allow); // R3
endmodule

bind flash_guard fg_checker #(
    .PAGE_W(PAGE_W), .GROUP_PAGES(GROUP_PAGES), .SAVE_CYCLES(SAVE_CYCLES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (stat_busy),
    .pass         (stat_pass),
    .fail         (stat_fail),
    .act_word     (act_prot),
    .vol_word     (vol_q),
    .nv_prot      (nv_prot),
    .nv_key       (nv_key),
    .acc_page     (acc_page),
    .acc_write    (acc_write),
    .acc_dbg_read (acc_dbg_read),
    .acc_allow    (acc_allow)
);

// File: tb/sim_flash_guard.sv
// Scoreboard bench: driver tasks push expected items, a monitor compares them.
module sim_flash_guard;
    localparam int PAGE_W = 7;
    localparam int SAVE_CYCLES = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_code = '0;
    logic        stat_busy, stat_pass, stat_fail;
    logic [PAGE_W-1:0] acc_page = '0;
    logic        acc_write = 1'b0;
    logic        acc_dbg_read = 1'b0;
    logic        acc_allow;

    always #5 clk = ~clk;

    flash_guard #(.PAGE_W(PAGE_W), .SAVE_CYCLES(SAVE_CYCLES)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .stat_busy(stat_busy), .stat_pass(stat_pass),
        .stat_fail(stat_fail), .acc_page(acc_page), .acc_write(acc_write),
        .acc_dbg_read(acc_dbg_read), .acc_allow(acc_allow)
    );

    typedef struct {
        bit          is_allow;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb[$];
    item_t it;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    function automatic void tally(input logic [31:0] got, input logic [31:0] exp, input string req);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endfunction

    // Monitor: compare pending expectations shortly after each falling edge.
    always begin
        @(negedge clk);
        #2;
        while (sb.size() > 0) begin
            it = sb.pop_front();
            if (it.is_allow) tally({31'b0, acc_allow}, it.exp, it.req);
            else             tally(bus_rdata, it.exp, it.req);
        end
    end

    task automatic exp_rd(input logic [2:0] a, input logic [31:0] e, input string r);
        @(negedge clk);
        bus_addr = a;
        sb.push_back('{1'b0, e, r});
        #4;
    endtask

    task automatic exp_acc(input int page, input bit wr, input bit dbg, input bit e, input string r);
        @(negedge clk);
        acc_page = PAGE_W'(page);
        acc_write = wr;
        acc_dbg_read = dbg;
        sb.push_back('{1'b1, {31'b0, e}, r});
        #4;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic run_cmd(input logic [7:0] code, output int busy_n);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = code;
        @(negedge clk);
        cmd_valid = 1'b0;
        busy_n = 0;
        while (stat_busy) begin
            busy_n++;
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic prep_save(input logic [31:0] word, input logic [7:0] mode, input logic [31:0] key);
        wr_reg(3'd3, word);
        wr_reg(3'd0, {24'b0, mode});
        wr_reg(3'd1, {16'b0, key[15:0]});
        wr_reg(3'd2, {16'b0, key[31:16]});
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R12 watchdog got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int nb;
        do_reset();
        // R1 reset values
        exp_rd(3'd0, 32'h80, "R1 mode");
        exp_rd(3'd1, 32'h0, "R1 keylo");
        exp_rd(3'd2, 32'h0, "R1 keyhi");
        exp_rd(3'd3, 32'h0, "R1 staged");
        exp_rd(3'd4, 32'hFFFF_FFFF, "R1 volatile");
        exp_rd(3'd5, 32'h0, "R1 status");
        exp_rd(3'd6, 32'hFFFF_FFFF, "R11 active from blank store");
        // R2 / R13 volatile page groups
        exp_acc(5, 1, 0, 1, "R2 write open before volatile");
        wr_reg(3'd4, 32'hFFFF_FFFD);
        exp_acc(4, 1, 0, 0, "R2 page 4 denied");
        exp_acc(7, 1, 0, 0, "R13 page 7 denied");
        exp_acc(3, 1, 0, 1, "R13 page 3 open");
        exp_acc(8, 1, 0, 1, "R13 page 8 open");
        wr_reg(3'd4, 32'hBFFF_FFFF);
        exp_acc(120, 1, 0, 0, "R13 page 120 denied");
        exp_acc(123, 1, 0, 0, "R13 page 123 denied");
        exp_acc(124, 1, 0, 1, "R13 page 124 open");
        wr_reg(3'd4, 32'h0);
        exp_acc(127, 1, 0, 1, "R13 page 127 never protected");
        // R3 debug read bit
        wr_reg(3'd4, 32'h7FFF_FFFF);
        exp_acc(0, 0, 1, 0, "R3 debug read denied");
        exp_acc(0, 0, 0, 1, "R3 plain read open");
        exp_acc(0, 1, 0, 1, "R3 write ignores bit 31");
        wr_reg(3'd4, 32'hFFFF_FFFF);
        exp_acc(0, 0, 1, 1, "R3 debug read open");
        exp_acc(4, 1, 0, 1, "R2 volatile cleared without key");
        // R7 bad mode bits
        prep_save(32'hFFFF_FFFB, 8'h68, 32'h5678_1234);
        exp_acc(8, 1, 0, 1, "R5 staged word no effect");
        run_cmd(8'h0C, nb);
        exp_rd(3'd5, 32'h4, "R7 fail with bit 5 set");
        wr_reg(3'd0, 32'h08);
        run_cmd(8'h0C, nb);
        exp_rd(3'd5, 32'h4, "R7 fail with bit 6 clear");
        do_reset();
        exp_rd(3'd6, 32'hFFFF_FFFF, "R7 store unchanged");
        // R6 good save
        prep_save(32'hFFFF_FFFB, 8'h48, 32'h5678_1234);
        run_cmd(8'h0C, nb);
        tally(32'(nb), 32'(SAVE_CYCLES), "R12 busy length");
        exp_rd(3'd5, 32'h2, "R6 save passes");
        exp_rd(3'd6, 32'hFFFF_FFFF, "R5 active waits for reset");
        exp_acc(8, 1, 0, 1, "R5 page 8 open before reset");
        wr_reg(3'd4, 32'h0000_FFFF);
        do_reset();
        exp_rd(3'd6, 32'hFFFF_FFFB, "R6 active after reset");
        exp_rd(3'd4, 32'hFFFF_FFFF, "R11 volatile reset");
        exp_acc(8, 1, 0, 0, "R6 page 8 denied");
        exp_acc(12, 1, 0, 1, "R6 page 12 open");
        // R4 merge of both words
        wr_reg(3'd4, 32'hFFFF_FFDF);
        exp_acc(20, 1, 0, 0, "R4 volatile group 5");
        exp_acc(9, 1, 0, 0, "R4 persistent group 2");
        exp_acc(12, 1, 0, 1, "R4 group 3 open");
        // R8 mismatched key
        do_reset();
        prep_save(32'hFFFF_FFF7, 8'h48, 32'h5678_1111);
        run_cmd(8'h0C, nb);
        exp_rd(3'd5, 32'h4, "R8 mismatch fails");
        do_reset();
        exp_rd(3'd6, 32'hFFFF_FFFB, "R8 store unchanged");
        // R8 matching key, R12 command while busy ignored
        prep_save(32'hFFFF_FFF7, 8'h48, 32'h5678_1234);
        @(negedge clk); cmd_valid = 1'b1; cmd_code = 8'h0C;
        @(negedge clk); cmd_code = 8'h0D;
        @(negedge clk); cmd_valid = 1'b0;
        while (stat_busy) @(negedge clk);
        exp_rd(3'd5, 32'h2, "R8 matching key passes");
        do_reset();
        exp_rd(3'd6, 32'hFFFF_FFF7, "R12 erase while busy ignored");
        // R10 mass erase
        run_cmd(8'h0D, nb);
        exp_rd(3'd5, 32'h2, "R10 erase passes");
        do_reset();
        exp_rd(3'd6, 32'hFFFF_FFFF, "R10 active cleared");
        // R9 permanent lock
        prep_save(32'hFFFF_FFFE, 8'h48, 32'hDEAD_DEAD);
        run_cmd(8'h0C, nb);
        exp_rd(3'd5, 32'h2, "R10 any key after erase");
        do_reset();
        exp_rd(3'd6, 32'hFFFF_FFFE, "R9 lock word active");
        exp_acc(0, 1, 0, 0, "R9 page 0 denied");
        prep_save(32'hFFFF_FFFF, 8'h48, 32'hDEAD_DEAD);
        run_cmd(8'h0C, nb);
        exp_rd(3'd5, 32'h4, "R9 locked save refused");
        do_reset();
        exp_rd(3'd6, 32'hFFFF_FFFE, "R9 lock holds after reset");
        run_cmd(8'h0D, nb);
        do_reset();
        exp_rd(3'd6, 32'hFFFF_FFFF, "R10 erase leaves lock");
        prep_save(32'hFFFF_FFFF, 8'h48, 32'h0000_0042);
        run_cmd(8'h0C, nb);
        exp_rd(3'd5, 32'h2, "R10 new key accepted");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule